// File: doc/BRIEF.md
# Video-Memory Contention Window Generator

This block marks, T-state by T-state, when a raster video controller that shares RAM with the CPU is busy fetching display data. It runs on a clock of one T-state per cycle and counts T-states from the frame interrupt. While the raster is inside the active display area, it raises two separate contention flags. One flag covers CPU memory accesses and the other covers CPU I/O accesses. Each flag follows its own fixed pattern inside every 8-T-state fetch group. The two windows overlap, but the memory window starts two T-states after the I/O window.

A clock-stretching stage uses the two flags to decide when to hold the CPU. The block also outputs the running frame T-state, the active line index and the fetch-group index, so that the display fetch logic can stay in step with the windows. All outputs are registered. In any cycle, the flags describe the T-state shown on the frame counter in that same cycle.

Top module: `contention_window_gen`

## Requirements
- R1: A synchronous reset, or an interrupt pulse sampled at a clock edge, sets `frame_tstate` to 0 after that edge. Each later edge without either signal adds one. The counter stops at its all-ones value (65535 with the default sizes) and never wraps.
- R2: `io_contend` is high at offsets 0 to 5 of each 8-T-state group and low at offsets 6 and 7. Offset is (T − 14336) mod 224 mod 8. For the first group of the first line, this means T-states 14336 to 14341.
- R3: `mem_contend` is high at offsets 2 to 7 of each group and low at offsets 0 and 1. For the first group, this means T-states 14338 to 14343.
- R4: Both edges of each window are contended and nothing is shifted to a neighbouring T-state. At 14335 both flags are low. At 14336 and 14341 the I/O flag is high, and at 14342 it is low. At 14343 the memory flag is high, and at 14344 it is low. At 14344 the I/O flag opens again, and at 14346 the memory flag opens again.
- R5: Within a line, only the first 16 groups (line positions 0 to 127 of 224) carry contention. At positions 128 to 223 both flags are low.
- R6: The active area is 192 lines. Line n starts at T-state 14336 + 224·n. Before T-state 14336, and from 14336 + 192·224 = 57344 onward, both flags are low.
- R7: Inside the active area, `line_idx` is the line number, (T − 14336) div 224. `group_idx` is the line position div 8 and covers 0 to 27. Outside the active area both are 0.
- R8: An interrupt in the middle of the active area ends the current frame at once. Both flags stay low until T-state 14336 of the new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Frame interrupt pulse, one cycle |
| io_contend | output | 1 | I/O contention flag for the current T-state |
| mem_contend | output | 1 | Memory contention flag for the current T-state |
| frame_tstate | output | T_W (16) | T-states since the last interrupt, saturating |
| line_idx | output | LINE_W (8) | Active line number, 0 outside the active area |
| group_idx | output | GRP_W (5) | Fetch group within the line, 0 outside the active area |

## Verification
The bench builds the block with its default sizes: first contended T-state 14336, 224-T-state lines, 192 active lines and 16 contended groups of 8. It therefore checks the exact T-states at which the windows open and close. One uninterrupted run covers the whole active area, the quiet tail of the frame and counter saturation at 65535. A second interrupt arrives in the middle of a line and tests the restart. A third frame then shows that contention returns at 14336.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  // True when a group offset falls inside an inclusive window [lo, hi].
  function automatic logic ofs_in_window(input int unsigned ofs,
                                         input int unsigned lo,
                                         input int unsigned hi);
    return (ofs >= lo) && (ofs <= hi);
  endfunction

endpackage

// File: rtl/cwg_frame_timer.sv
module cwg_frame_timer #(
  parameter int T_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           irq,
  output logic [T_W-1:0] t_q,
  output logic [T_W-1:0] t_next
);
  localparam logic [T_W-1:0] T_MAX = '1;

  always_comb begin
    if (rst || irq)        t_next = '0;
    else if (t_q == T_MAX) t_next = t_q;
    else                   t_next = t_q + 1'b1;
  end

  always_ff @(posedge clk) t_q <= t_next;

endmodule

// File: rtl/cwg_raster_tracker.sv
module cwg_raster_tracker #(
  parameter int FIRST_T      = 14336,
  parameter int LINE_T       = 224,
  parameter int ACTIVE_LINES = 192,
  parameter int GROUP_T      = 8,
  parameter int T_W          = 16,
  parameter int LINE_W       = 8,
  parameter int GRP_W        = 5,
  parameter int OFS_W        = 3,
  parameter int LPOS_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic [T_W-1:0]    t_next,
  output logic              zone_n,
  output logic [GRP_W-1:0]  grp_n,
  output logic [OFS_W-1:0]  ofs_n,
  output logic [LINE_W-1:0] line_q,
  output logic [GRP_W-1:0]  grp_q
);
  localparam logic [T_W-1:0]    FIRST_V = T_W'(FIRST_T);
  localparam logic [LPOS_W-1:0] LPOS_END = LPOS_W'(LINE_T - 1);
  localparam logic [LINE_W-1:0] LINE_END = LINE_W'(ACTIVE_LINES - 1);
  localparam logic [OFS_W-1:0]  OFS_END  = OFS_W'(GROUP_T - 1);

  logic              zone_q;
  logic [LPOS_W-1:0] lpos_q, lpos_n;
  logic [OFS_W-1:0]  ofs_q;
  logic [LINE_W-1:0] line_n;

  always_comb begin
    zone_n = 1'b0;
    lpos_n = '0;
    ofs_n  = '0;
    grp_n  = '0;
    line_n = '0;
    if (rst || irq) begin
      zone_n = 1'b0;
    end else if (t_next == FIRST_V) begin
      zone_n = 1'b1;
    end else if (zone_q) begin
      if (lpos_q == LPOS_END) begin
        if (line_q != LINE_END) begin
          zone_n = 1'b1;
          line_n = line_q + 1'b1;
        end
      end else begin
        zone_n = 1'b1;
        line_n = line_q;
        lpos_n = lpos_q + 1'b1;
        if (ofs_q == OFS_END) begin
          grp_n = grp_q + 1'b1;
        end else begin
          grp_n = grp_q;
          ofs_n = ofs_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    zone_q <= zone_n;
    lpos_q <= lpos_n;
    ofs_q  <= ofs_n;
    grp_q  <= grp_n;
    line_q <= line_n;
  end

endmodule

// File: rtl/cwg_window_flags.sv
module cwg_window_flags
  import cwg_pkg::*;
#(
  parameter int GROUP_T          = 8,
  parameter int CONTENDED_GROUPS = 16,
  parameter int IO_FIRST         = 0,
  parameter int IO_LAST          = 5,
  parameter int MEM_FIRST        = 2,
  parameter int MEM_LAST         = 7,
  parameter int GRP_W            = 5,
  parameter int OFS_W            = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zone_n,
  input  logic [GRP_W-1:0] grp_n,
  input  logic [OFS_W-1:0] ofs_n,
  output logic             io_q,
  output logic             mem_q
);
  localparam logic [GRP_W-1:0] GRP_LIMIT = GRP_W'(CONTENDED_GROUPS);

  logic [GROUP_T-1:0] io_mask;
  logic [GROUP_T-1:0] mem_mask;

  for (genvar g = 0; g < GROUP_T; g++) begin : g_mask
    assign io_mask[g]  = ofs_in_window(g, IO_FIRST, IO_LAST);
    assign mem_mask[g] = ofs_in_window(g, MEM_FIRST, MEM_LAST);
  end

  logic fetch_slot;
  assign fetch_slot = zone_n && (grp_n < GRP_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      io_q  <= 1'b0;
      mem_q <= 1'b0;
    end else begin
      io_q  <= fetch_slot && io_mask[ofs_n];
      mem_q <= fetch_slot && mem_mask[ofs_n];
    end
  end

endmodule

// File: rtl/contention_window_gen.sv
module contention_window_gen #(
  parameter int FIRST_T          = 14336,
  parameter int LINE_T           = 224,
  parameter int ACTIVE_LINES     = 192,
  parameter int GROUP_T          = 8,
  parameter int CONTENDED_GROUPS = 16,
  parameter int IO_FIRST         = 0,
  parameter int IO_LAST          = 5,
  parameter int MEM_FIRST        = 2,
  parameter int MEM_LAST         = 7,
  localparam int T_W    = $clog2(FIRST_T + ACTIVE_LINES * LINE_T + 1),
  localparam int LINE_W = $clog2(ACTIVE_LINES),
  localparam int GRP_W  = $clog2(LINE_T / GROUP_T),
  localparam int OFS_W  = $clog2(GROUP_T),
  localparam int LPOS_W = $clog2(LINE_T)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  output logic              io_contend,
  output logic              mem_contend,
  output logic [T_W-1:0]    frame_tstate,
  output logic [LINE_W-1:0] line_idx,
  output logic [GRP_W-1:0]  group_idx
);
  logic [T_W-1:0]   t_next;
  logic             zone_n;
  logic [GRP_W-1:0] grp_n;
  logic [OFS_W-1:0] ofs_n;

  cwg_frame_timer #(.T_W(T_W)) u_timer (
    .clk(clk), .rst(rst), .irq(irq),
    .t_q(frame_tstate), .t_next(t_next)
  );

  cwg_raster_tracker #(
    .FIRST_T(FIRST_T), .LINE_T(LINE_T), .ACTIVE_LINES(ACTIVE_LINES),
    .GROUP_T(GROUP_T), .T_W(T_W), .LINE_W(LINE_W), .GRP_W(GRP_W),
    .OFS_W(OFS_W), .LPOS_W(LPOS_W)
  ) u_track (
    .clk(clk), .rst(rst), .irq(irq), .t_next(t_next),
    .zone_n(zone_n), .grp_n(grp_n), .ofs_n(ofs_n),
    .line_q(line_idx), .grp_q(group_idx)
  );

  cwg_window_flags #(
    .GROUP_T(GROUP_T), .CONTENDED_GROUPS(CONTENDED_GROUPS),
    .IO_FIRST(IO_FIRST), .IO_LAST(IO_LAST),
    .MEM_FIRST(MEM_FIRST), .MEM_LAST(MEM_LAST),
    .GRP_W(GRP_W), .OFS_W(OFS_W)
  ) u_flags (
    .clk(clk), .rst(rst), .zone_n(zone_n), .grp_n(grp_n), .ofs_n(ofs_n),
    .io_q(io_contend), .mem_q(mem_contend)
  );

endmodule

// File: rtl/cwg_checker.sv
module cwg_checker #(
  parameter int T_W              = 16,
  parameter int GRP_W            = 5,
  parameter int FIRST_T          = 14336,
  parameter int LINE_T           = 224,
  parameter int ACTIVE_LINES     = 192,
  parameter int GROUP_T          = 8,
  parameter int CONTENDED_GROUPS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic [T_W-1:0]   frame_tstate,
  input logic             io_contend,
  input logic             mem_contend,
  input logic [GRP_W-1:0] group_idx
);
  localparam logic [T_W-1:0]   T_MAX   = '1;
  localparam logic [T_W-1:0]   FIRST_V = T_W'(FIRST_T);
  localparam logic [T_W-1:0]   END_V   = T_W'(FIRST_T + ACTIVE_LINES * LINE_T);
  localparam logic [T_W-1:0]   GRP_T_V = T_W'(GROUP_T);
  localparam logic [GRP_W-1:0] GRP_LIM = GRP_W'(CONTENDED_GROUPS);

  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    irq |=> (frame_tstate == '0));  // R1

  AST_TSTATE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!irq && frame_tstate != T_MAX) |=> (frame_tstate == $past(frame_tstate) + 1'b1));  // R1

  AST_IO_OPENS_ON_GROUP: assert property (@(posedge clk) disable iff (rst)
    $rose(io_contend) |-> (((frame_tstate - FIRST_V) % GRP_T_V) == '0));  // R2

  AST_MEM_INSIDE_IO_START: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_contend) |-> (io_contend && $past(io_contend)));  // R3

  AST_GROUP_CAP: assert property (@(posedge clk) disable iff (rst)
    (io_contend || mem_contend) |-> (group_idx < GRP_LIM));  // R5

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (frame_tstate < FIRST_V || frame_tstate >= END_V) |-> (!io_contend && !mem_contend));  // R6

endmodule

bind contention_window_gen cwg_checker #(
  .T_W(T_W), .GRP_W(GRP_W), .FIRST_T(FIRST_T), .LINE_T(LINE_T),
  .ACTIVE_LINES(ACTIVE_LINES), .GROUP_T(GROUP_T),
  .CONTENDED_GROUPS(CONTENDED_GROUPS)
) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .frame_tstate(frame_tstate),
  .io_contend(io_contend), .mem_contend(mem_contend), .group_idx(group_idx)
);

// File: tb/sim_contention_window_gen.sv
module sim_contention_window_gen;
  localparam int CLK_PERIOD = 10;
  localparam int FIRST_T    = 14336;
  localparam int LINE_T     = 224;
  localparam int LINES      = 192;
  localparam int GROUP_T    = 8;
  localparam int CGROUPS    = 16;
  localparam int T_MAX      = 65535;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    int  t;
    bit  io;
    bit  mem;
    int  line;
    int  grp;
    bit  restarted;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        io_contend, mem_contend;
  logic [15:0] frame_tstate;
  logic [7:0]  line_idx;
  logic [4:0]  group_idx;

  int   checks = 0;
  int   fails  = 0;
  int   model_t = 0;
  bit   after_restart = 1'b0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  contention_window_gen u0 (
    .clk(clk), .rst(rst), .irq(irq),
    .io_contend(io_contend), .mem_contend(mem_contend),
    .frame_tstate(frame_tstate), .line_idx(line_idx), .group_idx(group_idx)
  );

  function automatic exp_t predict(input int t, input bit rs);
    exp_t e;
    int rel, lp, ofs;
    bit zone;
    e.t = t; e.io = 0; e.mem = 0; e.line = 0; e.grp = 0; e.restarted = rs;
    zone = (t >= FIRST_T) && (t < FIRST_T + LINES * LINE_T);
    if (zone) begin
      rel = t - FIRST_T;
      lp  = rel % LINE_T;
      ofs = lp % GROUP_T;
      e.line = rel / LINE_T;
      e.grp  = lp / GROUP_T;
      e.io   = (e.grp < CGROUPS) && (ofs <= 5);
      e.mem  = (e.grp < CGROUPS) && (ofs >= 2);
    end
    return e;
  endfunction

  // Requirement tag for the flag checks of a given T-state.
  function automatic string flag_tag(input exp_t e, input string base);
    int rel;
    if (e.t == 14335 || e.t == 14336 || e.t == 14341 || e.t == 14342 ||
        e.t == 14343 || e.t == 14344 || e.t == 14346)
      return {base, "/R4 edge"};
    if (e.restarted && e.t < FIRST_T) return {base, "/R8 restart"};
    if (e.t < FIRST_T || e.t >= FIRST_T + LINES * LINE_T) return {base, "/R6 outside"};
    rel = (e.t - FIRST_T) % LINE_T;
    if (rel >= CGROUPS * GROUP_T) return {base, "/R5 line tail"};
    return base;
  endfunction

  // Driver: set inputs for the next edge and push the expected result.
  task automatic drive(input bit rst_v, input bit irq_v);
    @(negedge clk);
    rst = rst_v;
    irq = irq_v;
    if (rst_v || irq_v) model_t = 0;
    else if (model_t < T_MAX) model_t++;
    sb.push_back(predict(model_t, after_restart));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
  endtask

  task automatic cmp(input string tag, input int act, input int exp_v, input int t);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s at T=%0d: actual %0d expected %0d", tag, t, act, exp_v);
    end
  endtask

  // Monitor: after each edge, pop and compare.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.t == 0 ? "R1 reset/irq count" : "R1 count", int'(frame_tstate), e.t, e.t);
        cmp(flag_tag(e, "R2 io"),  int'(io_contend),  int'(e.io),  e.t);
        cmp(flag_tag(e, "R3 mem"), int'(mem_contend), int'(e.mem), e.t);
        cmp("R7 line",  int'(line_idx),  e.line, e.t);
        cmp("R7 group", int'(group_idx), e.grp,  e.t);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    // Full frame through active area, tail and saturation (R2..R7, R1 saturation)
    run(66000);
    // Second frame interrupted mid-line (R8)
    drive(1'b0, 1'b1);
    run(14400);
    after_restart = 1'b1;
    drive(1'b0, 1'b1);
    run(15000);
    after_restart = 1'b0;
    run(8);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule